// File: doc/BRIEF.md
# Synchronous flow-through burst SRAM

This block is a clocked single-port static memory of 2^ADDR_W words. Each word is 18 bits wide and split into two 9-bit byte lanes, each lane holding 8 data bits and 1 parity bit. A cache controller or a processor starts an access by pulling one of two address strobes low at a rising clock edge. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the byte write enables. After that first cycle, an advance input steps a 2-bit interleaved burst counter. When the advance input is held high, the current access repeats as a wait state.

Read data is flow-through. The word at the registered address is presented combinationally during the cycle after the loading edge, with no output register. The chip enable is captured only when an address strobe loads a new base. An asynchronous output enable, together with a drive flag, models the tri-state data bus. Separate input, output and output-enable ports stand in for the bidirectional pins.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected and `dq_oe_o` is 0.
- R2: A low `strb_p_n_i` at a rising edge loads `addr_i` as the base and latches the enable. If the enable is low, the cycle is a read of that address. `we_n_i`, `strb_c_n_i` and `adv_n_i` are ignored in that cycle, and any burst in progress is abandoned.
- R3: A low `strb_c_n_i` with `strb_p_n_i` high loads `addr_i` and latches the enable. If the enable is low, the cycle is a write of `wdata_i` when any bit of `we_n_i` is 0, and a read otherwise.
- R4: `ce_n_i` is sampled only on strobe cycles. A strobe cycle with `ce_n_i` high deselects the device. A change on `ce_n_i` during a burst has no effect.
- R5: A processor-strobe load followed by a cycle with both strobes high and a `we_n_i` bit low writes `wdata_i` to the loaded address. This is the two-cycle write.
- R6: On a cycle with both strobes high, a low `adv_n_i` steps the burst count before the access. A high `adv_n_i` repeats the access at the current address, for reads and for writes.
- R7: Address bits [ADDR_W-1:2] stay at the loaded base during a burst. Bits [1:0] equal the base bits [1:0] XOR a 2-bit count that starts at 0 on load. After four steps the address wraps back to the base.
- R8: `we_n_i[0]` low writes word bits [8:0] and `we_n_i[1]` low writes bits [17:9]. Either lane or both may be written in one cycle. A lane whose enable is high keeps its contents.
- R9: During the cycle after a read edge, `dq_o` shows the word stored at the address that edge selected.
- R10: `dq_oe_o` is 1 only during a selected read with `oe_n_i` low, and it follows `oe_n_i` without a clock. During writes and while deselected it is 0 whatever `oe_n_i` is. `dq_o` reads 0 whenever `dq_oe_o` is 0.
- R11: While deselected, cycles with both strobes high write nothing and do not drive the bus, whatever `adv_n_i` and `we_n_i` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External base address |
| strb_p_n_i | input | 1 | Processor address strobe, active low, highest priority |
| strb_c_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce_n_i | input | 1 | Chip enable, active low, sampled on strobe cycles |
| we_n_i | input | LANES | Byte-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANE_W*LANES | Write data |
| dq_o | output | LANE_W*LANES | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Bus drive flag |

## Verification
On every cycle, the assertions check the following:
- the bus-drive outcome one cycle after each kind of strobe cycle;
- that the upper address bits hold during bursts;
- that a suspended cycle leaves the access address unchanged.

The following can only be shown by the bench scenarios, by comparison against a memory model it keeps itself:
- memory contents and the interleaved order from every base;
- the wrap after four beats;
- byte-lane masking;
- the two-cycle write;
- suspended writes;
- the absence of writes while deselected.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    localparam int unsigned BURST_W = 2;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strb_p_n_i,
    input  logic              strb_c_n_i,
    input  logic              adv_n_i,
    input  logic              ce_n_i,
    input  logic [LANES-1:0]  we_n_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output acc_e              op_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [LANES-1:0]  wr_lane_o
);

    localparam int unsigned HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        logic               sel;
        acc_e               op;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic load_p, load_c, any_wr;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        load_p = ~strb_p_n_i;
        load_c = strb_p_n_i & ~strb_c_n_i;
        any_wr = |(~we_n_i);
        s_d    = s_q;

        if (load_p || load_c) begin
            s_d.base = addr_i;
            s_d.cnt  = '0;
            s_d.sel  = ~ce_n_i;
            if (ce_n_i)
                s_d.op = ACC_IDLE;
            else if (load_p)
                s_d.op = ACC_READ;
            else
                s_d.op = any_wr ? ACC_WRITE : ACC_READ;
        end else if (s_q.sel) begin
            s_d.cnt = s_q.cnt + {{(BURST_W-1){1'b0}}, ~adv_n_i};
            s_d.op  = any_wr ? ACC_WRITE : ACC_READ;
        end else begin
            s_d.op = ACC_IDLE;
        end

        nxt_addr  = {s_d.base[ADDR_W-1 -: HI_W], s_d.base[BURST_W-1:0] ^ s_d.cnt};
        wr_addr_o = nxt_addr;
        wr_lane_o = (s_d.op == ACC_WRITE) ? ~we_n_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{base: '0, cnt: '0, sel: 1'b0, op: ACC_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_addr_o = {s_q.base[ADDR_W-1 -: HI_W], s_q.base[BURST_W-1:0] ^ s_q.cnt};
    assign op_o       = s_q.op;

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lane_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [LANE_W*LANES-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [LANE_W*LANES-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane_i[g])
                lane_mem[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = lane_mem[rd_addr_i];
    end

endmodule

// File: rtl/burst_sram_outgate.sv
module burst_sram_outgate
    import burst_sram_pkg::*;
#(
    parameter int unsigned WORD_W = 18
) (
    input  acc_e              op_i,
    input  logic              oe_n_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe_o
);

    always_comb begin
        dq_oe_o = (op_i == ACC_READ) && !oe_n_i;
        dq_o    = dq_oe_o ? rd_data_i : '0;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strb_p_n_i,
    input  logic                    strb_c_n_i,
    input  logic                    adv_n_i,
    input  logic                    ce_n_i,
    input  logic [LANES-1:0]        we_n_i,
    input  logic                    oe_n_i,
    input  logic [LANE_W*LANES-1:0] wdata_i,
    output logic [LANE_W*LANES-1:0] dq_o,
    output logic                    dq_oe_o
);

    localparam int unsigned WORD_W = LANE_W * LANES;

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_lane;
    logic [WORD_W-1:0] rd_word;
    acc_e              op;

    burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .strb_p_n_i (strb_p_n_i),
        .strb_c_n_i (strb_c_n_i),
        .adv_n_i    (adv_n_i),
        .ce_n_i     (ce_n_i),
        .we_n_i     (we_n_i),
        .cur_addr_o (cur_addr),
        .op_o       (op),
        .wr_addr_o  (wr_addr),
        .wr_lane_o  (wr_lane)
    );

    burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk       (clk),
        .wr_lane_i (wr_lane),
        .wr_addr_i (wr_addr),
        .wr_data_i (wdata_i),
        .rd_addr_i (cur_addr),
        .rd_data_o (rd_word)
    );

    burst_sram_outgate #(.WORD_W(WORD_W)) u_out (
        .op_i      (op),
        .oe_n_i    (oe_n_i),
        .rd_data_i (rd_word),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe_o)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_p_n_i,
    input logic              strb_c_n_i,
    input logic              adv_n_i,
    input logic              ce_n_i,
    input logic [LANES-1:0]  we_n_i,
    input logic              oe_n_i,
    input logic              dq_oe_o,
    input logic [ADDR_W-1:0] cur_addr
);

    AST_PSTRB_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n_i && !ce_n_i) |=> (dq_oe_o == !oe_n_i)); // R2

    AST_CSTRB_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n_i && !strb_c_n_i && !ce_n_i && !(&we_n_i)) |=> !dq_oe_o); // R3

    AST_STRB_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_p_n_i || !strb_c_n_i) && ce_n_i) |=> !dq_oe_o); // R4

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n_i && strb_c_n_i && adv_n_i) |=> $stable(cur_addr)); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n_i && strb_c_n_i) |=>
            (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R7

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_p_n_i (strb_p_n_i),
    .strb_c_n_i (strb_c_n_i),
    .adv_n_i    (adv_n_i),
    .ce_n_i     (ce_n_i),
    .we_n_i     (we_n_i),
    .oe_n_i     (oe_n_i),
    .dq_oe_o    (dq_oe_o),
    .cur_addr   (cur_addr)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int AW = 6;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b0;
    logic [1:0]    we_n = 2'b11;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dq;
    logic          dq_oe;

    logic [DW-1:0] model [DEPTH];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    burst_sram i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .strb_p_n_i(sp_n), .strb_c_n_i(sc_n),
        .adv_n_i(adv_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .wdata_i(wdata), .dq_o(dq), .dq_oe_o(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 1237 + 91) ^ (a << 9));
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic p, input logic c, input logic a, input logic e,
                       input logic [1:0] w, input logic [DW-1:0] d, input logic [AW-1:0] ad);
        sp_n = p; sc_n = c; adv_n = a; ce_n = e; we_n = w; wdata = d; addr = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic exp_read(input int a, input string tag);
        chk({13'd0, dq_oe, dq}, {13'd0, 1'b1, model[a]}, tag);
    endtask

    task automatic exp_idle(input string tag);
        chk({13'd0, dq_oe, dq}, 32'd0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_idle("R1 reset state");

        // Fill through controller-strobe writes: R3, R10 (bus released on writes)
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1, 0, 1, 0, 2'b00, pat(a), AW'(a));
            model[a] = pat(a);
            exp_idle("R3 R10 write keeps bus released");
        end

        // Burst read from every base: R2, R9, R7, R6, R4 (ce ignored mid-burst)
        for (int b = 0; b < DEPTH; b++) begin
            cyc(0, 1, 1, 0, 2'b11, '0, AW'(b));
            exp_read(b, "R2 R9 processor strobe read");
            for (int k = 1; k < 4; k++) begin
                cyc(1, 1, 0, 1, 2'b11, '0, AW'(DEPTH - 1 - b));
                exp_read((b & ~3) | ((b & 3) ^ k), "R7 R4 interleaved beat");
            end
            cyc(1, 1, 1, 1, 2'b11, '0, '0);
            exp_read((b & ~3) | ((b & 3) ^ 3), "R6 wait state repeats");
            cyc(1, 1, 0, 0, 2'b11, '0, '0);
            exp_read(b, "R7 wrap to base");
        end

        // R2: write enables, controller strobe and advance ignored on processor strobe
        cyc(0, 0, 0, 0, 2'b00, ~pat(5), AW'(5));
        exp_read(5, "R2 strobe priority read");
        cyc(1, 1, 1, 0, 2'b11, '0, '0);
        exp_read(5, "R2 no write on processor strobe");

        // R3: controller strobe with no write enable reads
        cyc(1, 0, 1, 0, 2'b11, 18'h155AA, AW'(33));
        exp_read(33, "R3 controller read");

        // R5: two-cycle write
        cyc(0, 1, 1, 0, 2'b11, '0, AW'(20));
        exp_read(20, "R5 first cycle reads");
        cyc(1, 1, 1, 1, 2'b00, 18'h2A5C3, '0);
        model[20] = 18'h2A5C3;
        exp_idle("R5 second cycle writes");
        cyc(0, 1, 1, 0, 2'b11, '0, AW'(20));
        exp_read(20, "R5 readback");

        // R6: burst write with a suspended beat, base 10
        cyc(1, 0, 1, 0, 2'b00, 18'h11111, AW'(10));
        cyc(1, 1, 0, 0, 2'b00, 18'h22222, '0);
        cyc(1, 1, 1, 0, 2'b00, 18'h33333, '0);
        cyc(1, 1, 0, 0, 2'b00, 18'h04444, '0);
        exp_idle("R6 R10 burst write bus released");
        model[10] = 18'h11111; model[11] = 18'h33333; model[8] = 18'h04444;
        foreach (model[i]) if (i >= 8 && i < 12) begin
            cyc(0, 1, 1, 0, 2'b11, '0, AW'(i));
            exp_read(i, "R6 R7 suspended write readback");
        end

        // R8: byte lanes
        cyc(1, 0, 1, 0, 2'b10, 18'h3FFFF, AW'(30));
        model[30][8:0] = 9'h1FF;
        cyc(1, 0, 1, 0, 2'b01, 18'h00000, AW'(31));
        model[31][17:9] = 9'h000;
        cyc(0, 1, 1, 0, 2'b11, '0, AW'(30));
        exp_read(30, "R8 lower lane only");
        cyc(0, 1, 1, 0, 2'b11, '0, AW'(31));
        exp_read(31, "R8 upper lane only");

        // R10: output enable is asynchronous
        oe_n = 1'b1;
        cyc(0, 1, 1, 0, 2'b11, '0, AW'(40));
        exp_idle("R10 oe high releases bus");
        oe_n = 1'b0;
        #2;
        exp_read(40, "R10 oe low drives without clock");

        // R4, R11: deselect
        cyc(1, 0, 1, 1, 2'b00, 18'h0F0F0, AW'(50));
        exp_idle("R4 deselected controller strobe");
        for (int k = 0; k < 3; k++) begin
            cyc(1, 1, 0, 0, 2'b00, 18'h0F0F0, '0);
            exp_idle("R11 deselected advance");
        end
        cyc(0, 1, 1, 1, 2'b11, '0, AW'(51));
        exp_idle("R4 deselected processor strobe");
        cyc(1, 1, 1, 0, 2'b00, 18'h0F0F0, '0);
        exp_idle("R11 deselected write cycle");
        for (int a = 48; a < 52; a++) begin
            cyc(0, 1, 1, 0, 2'b11, '0, AW'(a));
            exp_read(a, "R11 no write while deselected");
        end

        cyc(1, 1, 1, 1, 2'b11, '0, '0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule